// File: doc/BRIEF.md
# Timeout-Framed Register Write Receiver

This block takes a byte stream from a serial receiver and turns it into register writes. Every message is three bytes long: a register address, a data byte and a check byte. The check byte must equal the modulo-256 sum of the address and the data. When a message is complete and its check byte matches, the data byte goes into a 256-entry byte register file. All registers drive the outputs in parallel, so that converters and other consumers can take their settings straight from the register file.

Message boundaries come from timing alone. While a partial message is held, a silence counter runs. It restarts on every accepted byte. If the silence lasts too long, the partial message is dropped and the next byte is taken as an address. A completed third byte ends the message at once, so the byte after it starts a new message with no wait. A message whose check byte does not match writes nothing. Instead it raises a one-cycle error pulse and bumps a saturating error counter.

The input is a valid/ready stream whose ready is held high, so the block never applies back-pressure. Each cycle with `in_valid` high transfers one byte. The sender needs to know only the timeout rule.

Top module: `frame_wr_rx`

## Requirements
- R1: `in_ready` is high in every cycle after reset, and every cycle with `in_valid` high consumes `in_data` as one byte.
- R2: Bytes are taken as address, data, check in that order. The edge that accepts the check byte closes the message, and the next byte accepted, even in the following cycle, is the address of a new message.
- R3: If the check byte equals (address + data) mod 256, then register[address] takes the data byte. The new value is visible on `reg_out` after the clock edge that follows the edge that accepted the check byte.
- R4: If the check byte does not match, no register changes. `err_pulse` is then high for exactly one cycle, at the same point in time that a write would have become visible.
- R5: `err_count` rises by one with each `err_pulse` and holds at 2^ERR_W-1 once it gets there. It never changes at any other time.
- R6: Take a partial message (one or two bytes held). If the next byte is accepted more than TIMEOUT_CYC clock edges after the previous accepted byte, the partial message is discarded and the new byte is an address. If the next byte comes TIMEOUT_CYC edges or fewer after the previous one, the message continues.
- R7: Reset clears every register to zero, clears `err_count` and `err_pulse`, and leaves the assembler waiting for an address.
- R8: While no partial message is held, silence of any length has no effect on outputs or on how the next byte is treated.
- R9: Register i appears at `reg_out[8*i+7:8*i]`, and at most one register byte changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always high; the block accepts every byte |
| in_data | input | 8 | Received byte |
| reg_out | output | 8*2^ADDR_W | All register contents, register i at bits 8i+7:8i |
| err_pulse | output | 1 | One-cycle pulse for a rejected message |
| err_count | output | ERR_W | Saturating count of rejected messages |

## Verification
If the assembler's position is wrong, a data byte gets treated as an address. The first complete message after that then fails its check or writes the wrong register, and this shows on `err_pulse` or `reg_out` two edges after the third byte. If the silence counter is wrong, the fault shows only for gaps right at the limit. For that reason the bench places bytes exactly TIMEOUT_CYC and TIMEOUT_CYC+1 edges apart. The bench's reference model compares the whole register image and the error outputs on every cycle, so a stray write or a lost write shows in the cycle after it happens.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_SUM  = 2'd2
  } slot_e;
endpackage

// File: rtl/frame_assembler.sv
module frame_assembler
  import frame_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              frame_done,
  output logic [BYTE_W-1:0] f_addr,
  output logic [BYTE_W-1:0] f_data,
  output logic [BYTE_W-1:0] f_sum
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  slot_e            slot;
  logic [CW-1:0]    idle_cnt;
  logic             done_q;
  logic [BYTE_W-1:0] slot_q [FRAME_BYTES];

  // Position and silence tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= SLOT_ADDR;
      idle_cnt <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (byte_vld) begin
        idle_cnt <= '0;
        if (slot == SLOT_SUM) begin
          slot   <= SLOT_ADDR;
          done_q <= 1'b1;
        end else begin
          slot <= slot_e'(slot + 2'd1);
        end
      end else if (slot != SLOT_ADDR) begin
        if (idle_cnt == CW'(TIMEOUT_CYC - 1)) begin
          slot     <= SLOT_ADDR;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  // Frame buffer, one register per byte position
  for (genvar s = 0; s < FRAME_BYTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (byte_vld && slot == slot_e'(s))
        slot_q[s] <= byte_in;
    end
  end

  assign frame_done = done_q;
  assign f_addr     = slot_q[SLOT_ADDR];
  assign f_data     = slot_q[SLOT_DATA];
  assign f_sum      = slot_q[SLOT_SUM];
endmodule

// File: rtl/frame_checker.sv
module frame_checker
  import frame_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [BYTE_W-1:0] f_addr,
  input  logic [BYTE_W-1:0] f_data,
  input  logic [BYTE_W-1:0] f_sum,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              err_pulse,
  output logic [ERR_W-1:0]  err_count
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [BYTE_W-1:0] calc_sum;
  logic              sum_ok;

  assign calc_sum = f_addr + f_data;
  assign sum_ok   = (calc_sum == f_sum);
  assign wr_en    = frame_done && sum_ok;
  assign wr_addr  = f_addr[ADDR_W-1:0];
  assign wr_data  = f_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_count <= '0;
    end else begin
      err_pulse <= frame_done && !sum_ok;
      if (frame_done && !sum_ok && err_count != ERR_MAX)
        err_count <= err_count + 1'b1;
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import frame_rx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [(1<<ADDR_W)*BYTE_W-1:0] regs_flat
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        q <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/frame_wr_rx.sv
module frame_wr_rx
  import frame_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2_500_000,
  parameter int ADDR_W      = 8,
  parameter int ERR_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [7:0]                    in_data,
  output logic [(1<<ADDR_W)*8-1:0]      reg_out,
  output logic                          err_pulse,
  output logic [ERR_W-1:0]              err_count
);
  logic              byte_vld;
  logic              frame_done;
  logic [BYTE_W-1:0] f_addr, f_data, f_sum;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  assign in_ready = 1'b1;
  assign byte_vld = in_valid && in_ready;

  frame_assembler #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(in_data),
    .frame_done(frame_done), .f_addr(f_addr), .f_data(f_data), .f_sum(f_sum)
  );

  frame_checker #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk_sum (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .f_addr(f_addr), .f_data(f_data), .f_sum(f_sum),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_pulse(err_pulse), .err_count(err_count)
  );

  reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(reg_out)
  );
endmodule

// File: rtl/frame_wr_rx_chk.sv
module frame_wr_rx_chk #(
  parameter int ADDR_W = 8,
  parameter int ERR_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_ready,
  input logic [(1<<ADDR_W)*8-1:0] reg_out,
  input logic                     err_pulse,
  input logic [ERR_W-1:0]         err_count
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [(1<<ADDR_W)*8-1:0] prev_regs;
  logic [DEPTH-1:0]         chg_mask;

  always_ff @(posedge clk) prev_regs <= reg_out;

  for (genvar i = 0; i < DEPTH; i++) begin : g_chg
    assign chg_mask[i] = reg_out[i*8 +: 8] != prev_regs[i*8 +: 8];
  end

  // R1
  in_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R4
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R4
  reject_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> reg_out == $past(reg_out));

  // R5
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(err_count) != ERR_MAX) |-> err_count == $past(err_count) + 1'b1);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> $stable(err_count));

  // R9
  one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(chg_mask) <= 1);
endmodule

bind frame_wr_rx frame_wr_rx_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_frame_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .reg_out(reg_out),
  .err_pulse(err_pulse), .err_count(err_count)
);

// File: tb/frame_wr_rx_tb.sv
module frame_wr_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 8;
  localparam int AW         = 8;
  localparam int EW         = 2;
  localparam int DEPTH      = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [7:0]           in_data = '0;
  logic [DEPTH*8-1:0]   reg_out;
  logic                 err_pulse;
  logic [EW-1:0]        err_count;

  int checks = 0;
  int fails  = 0;

  frame_wr_rx #(.TIMEOUT_CYC(LIM), .ADDR_W(AW), .ERR_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_out(reg_out), .err_pulse(err_pulse), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_reg [DEPTH];
  int m_pos, m_gap, m_pend, m_err, m_cnt;
  int m_buf [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_pos = 0; m_gap = 0; m_pend = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_err = 0;
      if (m_pend != 0) begin
        if (((m_buf[0] + m_buf[1]) % 256) == m_buf[2]) m_reg[m_buf[0]] = m_buf[1];
        else begin
          m_err = 1;
          if (m_cnt < (1 << EW) - 1) m_cnt++;
        end
        m_pend = 0;
      end
      if (in_valid) begin
        m_buf[m_pos] = int'(in_data);
        m_gap = 0;
        m_pos++;
        if (m_pos == 3) begin m_pos = 0; m_pend = 1; end
      end else if (m_pos != 0) begin
        m_gap++;
        if (m_gap >= LIM) begin m_pos = 0; m_gap = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int bad_i;
      bad_i = -1;
      for (int i = 0; i < DEPTH; i++)
        if (int'(reg_out[i*8 +: 8]) != m_reg[i] && bad_i < 0) bad_i = i;
      chk(bad_i < 0, "R3 register image", (bad_i < 0) ? 0 : int'(reg_out[bad_i*8 +: 8]),
          (bad_i < 0) ? 0 : m_reg[bad_i]);
      chk(int'(err_pulse) == m_err, "R4 err_pulse", int'(err_pulse), m_err);
      chk(int'(err_count) == m_cnt, "R5 err_count", int'(err_count), m_cnt);
      chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    end
  end

  function automatic int rd(input int a);
    return int'(reg_out[a*8 +: 8]);
  endfunction

  task automatic send_byte(input logic [7:0] d, input int idle);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    for (int k = 1; k < idle; k++) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input logic [7:0] s);
    send_byte(a, 0);
    send_byte(d, 0);
    send_byte(s, 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle_cycles(4);
    rst_n = 1'b1;
    idle_cycles(1);
    // R7 reset state
    chk(reg_out == '0, "R7 regs zero", rd(0), 0);
    chk(err_count == '0 && !err_pulse, "R7 err clear", int'(err_count), 0);

    // R3 good frame, R9 field position
    send_frame(8'h12, 8'h34, 8'h46);
    idle_cycles(2);
    chk(rd(8'h12) == 8'h34, "R3 write 0x12", rd(8'h12), 8'h34);
    chk(rd(8'h13) == 0 && rd(8'h11) == 0, "R9 neighbours untouched", rd(8'h13), 0);

    // R4 bad check byte
    send_frame(8'h40, 8'h01, 8'h00);
    idle_cycles(2);
    chk(rd(8'h40) == 0, "R4 no write on bad sum", rd(8'h40), 0);
    chk(err_count == 2'd1, "R5 count one", int'(err_count), 1);

    // R2 back-to-back frames, extremes of address
    send_frame(8'h00, 8'hAA, 8'hAA);
    send_frame(8'hFF, 8'h55, 8'h54);
    idle_cycles(2);
    chk(rd(0) == 8'hAA, "R2 first of pair", rd(0), 8'hAA);
    chk(rd(255) == 8'h55, "R2 second of pair", rd(255), 8'h55);

    // R3 modulo-256 wrap
    send_frame(8'hF0, 8'h20, 8'h10);
    idle_cycles(2);
    chk(rd(8'hF0) == 8'h20, "R3 wrapped sum", rd(8'hF0), 8'h20);

    // R6 gap of exactly LIM edges continues the frame
    send_byte(8'h21, LIM - 1);
    send_byte(8'h07, LIM - 1);
    send_byte(8'h28, 0);
    idle_cycles(2);
    chk(rd(8'h21) == 8'h07, "R6 gap at limit kept", rd(8'h21), 8'h07);

    // R6 gap of LIM+1 edges drops the partial frame
    send_byte(8'h05, LIM);
    send_frame(8'h06, 8'h77, 8'h7D);
    idle_cycles(2);
    chk(rd(8'h06) == 8'h77, "R6 restart after timeout", rd(8'h06), 8'h77);
    chk(rd(8'h05) == 0 && err_count == 2'd1, "R6 partial dropped", rd(8'h05), 0);

    // R8 long idle with nothing held
    idle_cycles(LIM * 5);
    send_frame(8'h30, 8'h03, 8'h33);
    idle_cycles(2);
    chk(rd(8'h30) == 8'h03, "R8 after long idle", rd(8'h30), 8'h03);

    // R5 saturation
    for (int n = 0; n < 4; n++) send_frame(8'h50, 8'h50, 8'h00);
    idle_cycles(2);
    chk(err_count == 2'd3, "R5 saturated", int'(err_count), 3);
    chk(rd(8'h50) == 0, "R4 rejected frames wrote nothing", rd(8'h50), 0);

    idle_cycles(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule